// File: doc/BRIEF.md
# Sequenced SPI Master with Chip-Select Timing

This block is an SPI master engine that sends and receives frames of 1 to 16 bits. The writer hands it one word at a time. Each word carries its transmit data and its own control fields. Those fields set the frame length and name the select lines to leave released during the frame. They also mark whether the word closes a frame or a whole transfer, and whether the bits clocked in during the frame should be dropped. A one-word holding slot sits in front of the shifter, so the next word can wait while the current frame is on the wire.

Four delay settings shape the chip-select timing, each 0 to 15 SPI clock periods long. The first is a lead time from a select going active to the first clock edge. The second is a tail time from the last clock edge of a closing frame to the select release. The third is a minimum gap after a frame-closing word. The fourth is a minimum off-time of the selects between transfers. A divider sets the timing base. Clock polarity, clock phase, bit order and a polarity bit for each select come from static configuration inputs. These inputs are changed only while the master is idle.

Top module: `spi_seq_master`

## Requirements
- R1: The word's length field holds the frame length minus one (4 bits), so a frame has between 1 and 16 SCK cycles, one for each bit.
- R2: With `cfg_lsb_first` low, data bit `flen` leaves on MOSI first and bit 0 leaves last. With it high, the order is reversed. Received bits are placed at the same index as the bit sent in the same cycle.
- R3: SCK rests at `cfg_cpol` outside frames. With `cfg_cpha` low, MOSI is valid before the leading edge and both sides sample on the leading edge. With `cfg_cpha` high, MOSI changes on the leading edge and sampling happens on the trailing edge.
- R4: Each SCK half period lasts `cfg_div`+1 input clocks, and one SPI clock period is two half periods.
- R5: When a select goes active at the start of a transfer, the first SCK edge follows after (2·pre+1)·(div+1) input clocks.
- R6: After the last SCK edge of an end-of-transfer word, the selects are released exactly 2·post·(div+1) input clocks later.
- R7: After a word tagged end-of-frame, the gap from its last SCK edge to the next frame's first edge is (2·frame+1)·(div+1)+1 clocks. Without the tag, the gap is (div+1)+1 and the selects stay active.
- R8: A word tagged end-of-transfer releases all selects after its frame. The selects stay released for 2·xfer·(div+1)+1 clocks before the next word asserts them.
- R9: Bit i of a word's 4-bit release field set to 1 keeps select i deasserted for that frame, and 0 asserts it. The pin's asserted level is `cfg_sel_pol[i]` (1 = active high), and the deasserted level is its inverse.
- R10: After each frame, `rx_valid` pulses for one clock, with the received bits in `rx_data` and zeros above the frame length.
- R11: A word with its receive-ignore bit set produces no `rx_valid` pulse.
- R12: `tx_ready` is high when the holding slot is empty. A write while it is low is dropped, and that word is never sent.
- R13: `master_idle` is high only when the slot is empty and the selects have been released after their tail and transfer delays.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cpol | input | 1 | SCK rest level |
| cfg_cpha | input | 1 | 0: sample on leading edge, 1: on trailing edge |
| cfg_lsb_first | input | 1 | Bit order select |
| cfg_sel_pol | input | 4 | Asserted level of each select |
| cfg_div | input | 16 | Half-period length minus one, in input clocks |
| cfg_pre | input | 4 | Lead time before the first edge |
| cfg_post | input | 4 | Tail time before release |
| cfg_frame | input | 4 | Minimum gap after an end-of-frame word |
| cfg_xfer | input | 4 | Minimum select-off time between transfers |
| wr_valid | input | 1 | Write strobe for one word |
| wr_data | input | 16 | Transmit data |
| wr_flen | input | 4 | Frame length minus one |
| wr_rel | input | 4 | Select release mask, 1 = deasserted |
| wr_eof | input | 1 | Word ends a frame |
| wr_eot | input | 1 | Word ends a transfer |
| wr_rx_ign | input | 1 | Drop the received bits |
| tx_ready | output | 1 | Holding slot empty |
| sck | output | 1 | SPI clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| sel | output | 4 | Select lines |
| rx_valid | output | 1 | Received word strobe |
| rx_data | output | 16 | Received word |
| master_idle | output | 1 | Nothing queued, selects released |

## Verification
The assertions assume that all `cfg_*` inputs are held constant while a word is queued or being processed. Under that assumption, the divider count never exceeds the divider value, and the SCK and select relations hold. The stimulus changes configuration only after `master_idle` has been seen high. It ends every sequence with an end-of-transfer word, so the engine always returns to idle. MISO is looped back from MOSI through an inverter. This gives received data that is known in advance in every mode and still separates received bits from transmitted ones.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;
  localparam int MAX_BITS = 16;
  localparam int NSEL     = 4;
  localparam int LEN_W    = $clog2(MAX_BITS);

  typedef struct packed {
    logic [NSEL-1:0]     rel;
    logic                eot;
    logic                eof;
    logic                rx_ign;
    logic [LEN_W-1:0]    flen;
    logic [MAX_BITS-1:0] data;
  } spi_word_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_SHIFT, ST_POST, ST_XGAP, ST_FGAP, ST_WAIT
  } eng_state_e;
endpackage

// File: rtl/spi_rate_tick.sv
module spi_rate_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == div);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  a_r4_cnt_in_range: assert property (@(posedge clk) disable iff (rst)
    cnt <= div);
endmodule

// File: rtl/spi_word_slot.sv
module spi_word_slot
  import spi_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      wr_valid,
  input  spi_word_t wr_word,
  input  logic      take,
  output logic      full,
  output spi_word_t word
);
  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
      word <= '0;
    end else if (take) begin
      full <= 1'b0;
    end else if (wr_valid && !full) begin
      full <= 1'b1;
      word <= wr_word;
    end
  end

  a_r12_full_keeps_word: assert property (@(posedge clk) disable iff (rst)
    (full && !take) |=> (full && $stable(word)));
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_seq_pkg::*;
#(
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             cpha,
  input  logic             lsb_first,
  input  logic [DLY_W-1:0] d_pre,
  input  logic [DLY_W-1:0] d_post,
  input  logic [DLY_W-1:0] d_frame,
  input  logic [DLY_W-1:0] d_xfer,
  input  logic             hold_valid,
  input  spi_word_t        hold_word,
  input  logic             miso,
  output logic             take,
  output logic             run,
  output logic             at_idle,
  output logic             sck_act,
  output logic             mosi,
  output logic [NSEL-1:0]  sel_act,
  output logic             rx_valid,
  output logic [MAX_BITS-1:0] rx_data
);
  localparam int DC_W = DLY_W + 1;

  eng_state_e          state;
  spi_word_t           cur;
  logic [LEN_W-1:0]    bcnt;
  logic                half;
  logic [DC_W-1:0]     dcnt;
  logic [MAX_BITS-1:0] rx_sh, rx_cap;
  logic [LEN_W-1:0]    idx, idx_nx;

  function automatic logic [DC_W-1:0] twice(input logic [DLY_W-1:0] d);
    return {d, 1'b0};
  endfunction

  assign take    = (state == ST_IDLE || state == ST_WAIT) && hold_valid;
  assign run     = !(state == ST_IDLE || state == ST_WAIT);
  assign at_idle = (state == ST_IDLE);
  assign idx     = lsb_first ? bcnt : cur.flen - bcnt;
  assign idx_nx  = lsb_first ? bcnt + 1'b1 : cur.flen - bcnt - 1'b1;

  always_comb begin
    rx_cap      = rx_sh;
    rx_cap[idx] = miso;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cur      <= '0;
      bcnt     <= '0;
      half     <= 1'b0;
      dcnt     <= '0;
      rx_sh    <= '0;
      sck_act  <= 1'b0;
      mosi     <= 1'b0;
      sel_act  <= '0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else begin
      rx_valid <= 1'b0;
      case (state)
        ST_IDLE, ST_WAIT: begin
          if (hold_valid) begin
            cur     <= hold_word;
            bcnt    <= '0;
            half    <= 1'b0;
            dcnt    <= '0;
            rx_sh   <= '0;
            sel_act <= ~hold_word.rel;
            if (!cpha)
              mosi <= hold_word.data[lsb_first ? '0 : hold_word.flen];
            if (state == ST_IDLE && d_pre != '0) state <= ST_PRE;
            else                                 state <= ST_SHIFT;
          end
        end
        ST_PRE: if (tick) begin
          if (dcnt + 1'b1 == twice(d_pre)) begin
            dcnt  <= '0;
            state <= ST_SHIFT;
          end else dcnt <= dcnt + 1'b1;
        end
        ST_SHIFT: if (tick) begin
          if (!half) begin
            sck_act <= 1'b1;
            half    <= 1'b1;
            if (!cpha) rx_sh[idx] <= miso;
            else       mosi <= cur.data[idx];
          end else begin
            sck_act <= 1'b0;
            half    <= 1'b0;
            if (cpha) rx_sh[idx] <= miso;
            if (bcnt == cur.flen) begin
              rx_valid <= !cur.rx_ign;
              rx_data  <= cpha ? rx_cap : rx_sh;
              dcnt     <= '0;
              if (cur.eot) begin
                if (d_post != '0)      state <= ST_POST;
                else begin
                  sel_act <= '0;
                  state   <= (d_xfer != '0) ? ST_XGAP : ST_IDLE;
                end
              end else if (cur.eof && d_frame != '0) state <= ST_FGAP;
              else                                    state <= ST_WAIT;
            end else begin
              bcnt <= bcnt + 1'b1;
              if (!cpha) mosi <= cur.data[idx_nx];
            end
          end
        end
        ST_POST: if (tick) begin
          if (dcnt + 1'b1 == twice(d_post)) begin
            dcnt    <= '0;
            sel_act <= '0;
            state   <= (d_xfer != '0) ? ST_XGAP : ST_IDLE;
          end else dcnt <= dcnt + 1'b1;
        end
        ST_XGAP: if (tick) begin
          if (dcnt + 1'b1 == twice(d_xfer)) begin
            dcnt  <= '0;
            state <= ST_IDLE;
          end else dcnt <= dcnt + 1'b1;
        end
        ST_FGAP: if (tick) begin
          if (dcnt + 1'b1 == twice(d_frame)) begin
            dcnt  <= '0;
            state <= ST_WAIT;
          end else dcnt <= dcnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  a_r1_bit_bound: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SHIFT) |-> (bcnt <= cur.flen));
  a_r3_sck_rests: assert property (@(posedge clk) disable iff (rst)
    (state != ST_SHIFT) |-> !sck_act);
  a_r9_sel_fixed_in_frame: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SHIFT && $past(state == ST_SHIFT)) |-> $stable(sel_act));
  a_r10_rx_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);
  a_r11_ignored_no_pulse: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> !cur.rx_ign);
  a_r13_idle_released: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> (sel_act == '0));
endmodule

// File: rtl/spi_seq_master.sv
module spi_seq_master
  import spi_seq_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int DLY_W = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_cpol,
  input  logic                cfg_cpha,
  input  logic                cfg_lsb_first,
  input  logic [NSEL-1:0]     cfg_sel_pol,
  input  logic [DIV_W-1:0]    cfg_div,
  input  logic [DLY_W-1:0]    cfg_pre,
  input  logic [DLY_W-1:0]    cfg_post,
  input  logic [DLY_W-1:0]    cfg_frame,
  input  logic [DLY_W-1:0]    cfg_xfer,
  input  logic                wr_valid,
  input  logic [MAX_BITS-1:0] wr_data,
  input  logic [LEN_W-1:0]    wr_flen,
  input  logic [NSEL-1:0]     wr_rel,
  input  logic                wr_eof,
  input  logic                wr_eot,
  input  logic                wr_rx_ign,
  output logic                tx_ready,
  output logic                sck,
  output logic                mosi,
  input  logic                miso,
  output logic [NSEL-1:0]     sel,
  output logic                rx_valid,
  output logic [MAX_BITS-1:0] rx_data,
  output logic                master_idle
);
  spi_word_t       in_word, slot_word;
  logic            slot_full, take, run, tick, at_idle, sck_act;
  logic [NSEL-1:0] sel_act;

  assign in_word = '{rel: wr_rel, eot: wr_eot, eof: wr_eof, rx_ign: wr_rx_ign,
                     flen: wr_flen, data: wr_data};

  spi_word_slot u_slot (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_word(in_word),
    .take(take), .full(slot_full), .word(slot_word)
  );

  spi_rate_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst(rst), .run(run), .div(cfg_div), .tick(tick)
  );

  spi_shift_engine #(.DLY_W(DLY_W)) u_eng (
    .clk(clk), .rst(rst), .tick(tick), .cpha(cfg_cpha), .lsb_first(cfg_lsb_first),
    .d_pre(cfg_pre), .d_post(cfg_post), .d_frame(cfg_frame), .d_xfer(cfg_xfer),
    .hold_valid(slot_full), .hold_word(slot_word), .miso(miso),
    .take(take), .run(run), .at_idle(at_idle), .sck_act(sck_act), .mosi(mosi),
    .sel_act(sel_act), .rx_valid(rx_valid), .rx_data(rx_data)
  );

  assign tx_ready    = !slot_full;
  assign sck         = sck_act ^ cfg_cpol;
  assign master_idle = at_idle && !slot_full;

  for (genvar i = 0; i < NSEL; i++) begin : g_sel
    assign sel[i] = sel_act[i] ? cfg_sel_pol[i] : ~cfg_sel_pol[i];
  end

  a_r12_no_take_when_empty: assert property (@(posedge clk) disable iff (rst)
    take |-> !tx_ready);
endmodule

// File: tb/spi_seq_master_tb.sv
module spi_seq_master_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cpol = 0, cpha = 0, lsb = 0;
  logic [3:0]  pol = 4'h0;
  logic [15:0] div = 16'd1;
  logic [3:0]  pre = 0, post = 0, fgap = 0, xgap = 0;
  logic wr_valid = 0, wr_eof = 0, wr_eot = 0, wr_ign = 0;
  logic [15:0] wr_data = 0;
  logic [3:0]  wr_flen = 0, wr_rel = 0;
  logic tx_ready, sck, mosi, miso, rx_valid, master_idle;
  logic [3:0]  sel;
  logic [15:0] rx_data;

  int errors = 0, checks = 0, cyc = 0;

  assign miso = ~mosi;

  spi_seq_master u_dut (
    .clk(clk), .rst(rst), .cfg_cpol(cpol), .cfg_cpha(cpha), .cfg_lsb_first(lsb),
    .cfg_sel_pol(pol), .cfg_div(div), .cfg_pre(pre), .cfg_post(post),
    .cfg_frame(fgap), .cfg_xfer(xgap), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_flen(wr_flen), .wr_rel(wr_rel), .wr_eof(wr_eof), .wr_eot(wr_eot),
    .wr_rx_ign(wr_ign), .tx_ready(tx_ready), .sck(sck), .mosi(mosi), .miso(miso),
    .sel(sel), .rx_valid(rx_valid), .rx_data(rx_data), .master_idle(master_idle)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // port monitor, sampled away from the active edge
  int lead_t[64], trail_t[64], on_t[8], off_t[8], rx_log[8];
  logic cap[64];
  logic [3:0] sel_at_lead;
  int n_lead, n_trail, n_cap, n_on, n_off, n_rx;
  logic p_sck = 0;
  logic [3:0] p_sel = 4'hF;

  task automatic clr_mon();
    n_lead = 0; n_trail = 0; n_cap = 0; n_on = 0; n_off = 0; n_rx = 0;
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (sck != p_sck) begin
        if (sck != cpol) begin
          if (n_lead == 0) sel_at_lead = sel;
          if (n_lead < 64) lead_t[n_lead] = cyc;
          n_lead++;
          if (!cpha && n_cap < 64) begin cap[n_cap] = mosi; n_cap++; end
        end else begin
          if (n_trail < 64) trail_t[n_trail] = cyc;
          n_trail++;
          if (cpha && n_cap < 64) begin cap[n_cap] = mosi; n_cap++; end
        end
      end
      if (sel != p_sel) begin
        if (p_sel == ~pol && n_on < 8) begin on_t[n_on] = cyc; n_on++; end
        if (sel == ~pol && n_off < 8) begin off_t[n_off] = cyc; n_off++; end
      end
      if (rx_valid && n_rx < 8) begin rx_log[n_rx] = rx_data; n_rx++; end
    end
    p_sck = sck;
    p_sel = sel;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put(input logic [15:0] d, input logic [3:0] fl, input logic [3:0] rl,
                     input logic eof, input logic eot, input logic ign);
    while (!tx_ready) @(negedge clk);
    wr_data = d; wr_flen = fl; wr_rel = rl; wr_eof = eof; wr_eot = eot; wr_ign = ign;
    wr_valid = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (3) @(negedge clk);
    while (!master_idle) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic setup(input logic cp, input logic ch, input logic lf, input int dv,
                       input int a, input int b, input int c, input int e);
    cpol = cp; cpha = ch; lsb = lf; div = 16'(dv);
    pre = 4'(a); post = 4'(b); fgap = 4'(c); xgap = 4'(e);
    repeat (2) @(negedge clk);
    clr_mon();
  endtask

  function automatic int rx_exp(input logic [15:0] d, input int fl);
    logic [16:0] m;
    m = (17'd1 << (fl + 1)) - 17'd1;
    return int'((~d) & m[15:0]);
  endfunction

  task automatic t_reset();
    check("R3 sck rest after reset", sck, 0);
    check("R9 selects released after reset", sel, 4'hF);
    check("R12 tx_ready after reset", tx_ready, 1);
    check("R13 master_idle after reset", master_idle, 1);
    check("R10 no rx_valid after reset", rx_valid, 0);
  endtask

  task automatic t_frame(input logic cp, input logic ch, input logic lf, input int dv,
                         input logic [15:0] d, input int fl);
    int bad = 0;
    int T = dv + 1;
    setup(cp, ch, lf, dv, 0, 0, 0, 0);
    put(d, 4'(fl), 4'h0, 1'b1, 1'b1, 1'b0);
    wait_idle();
    check("R1 edge count equals length", n_lead, fl + 1);
    for (int k = 0; k <= fl; k++)
      if (cap[k] != d[lf ? k : fl - k]) bad++;
    check("R2/R3 bit order at sample edge", bad, 0);
    check("R10 one rx word", n_rx, 1);
    check("R10 rx data", rx_log[0], rx_exp(d, fl));
    check("R3 sck rests at polarity", sck, cp);
    if (fl > 0) check("R4 sck period", lead_t[1] - lead_t[0], 2 * T);
  endtask

  task automatic t_delays(input int a, input int b, input int dv);
    int T = dv + 1;
    setup(0, 0, 0, dv, a, b, 0, 0);
    put(16'h3C, 4'd5, 4'h0, 1'b0, 1'b1, 1'b0);
    wait_idle();
    check("R5 lead time", lead_t[0] - on_t[0], (2 * a + 1) * T);
    check("R6 tail time", off_t[0] - trail_t[5], 2 * b * T);
  endtask

  task automatic t_frames(input int f, input logic eof, input int dv);
    int T = dv + 1;
    setup(1, 0, 0, dv, 1, 0, f, 0);
    put(16'h5, 4'd3, 4'h0, eof, 1'b0, 1'b0);
    put(16'hA, 4'd3, 4'h0, 1'b0, 1'b1, 1'b0);
    wait_idle();
    check("R7 frame gap", lead_t[4] - trail_t[3], eof ? (2 * f + 1) * T + 1 : T + 1);
    check("R7 selects held across frames", n_off, 1);
  endtask

  task automatic t_xfer(input int x, input int dv);
    int T = dv + 1;
    setup(0, 1, 0, dv, 0, 1, 0, x);
    put(16'h9, 4'd3, 4'h0, 1'b0, 1'b1, 1'b0);
    put(16'h6, 4'd3, 4'h0, 1'b0, 1'b1, 1'b0);
    wait_idle();
    check("R8 two releases", n_off, 2);
    check("R8 select off time", on_t[1] - off_t[0], 2 * x * T + 1);
  endtask

  task automatic t_selmask();
    pol = 4'b0101;
    setup(0, 0, 0, 1, 0, 0, 0, 0);
    check("R9 released level follows polarity", sel, 4'b1010);
    put(16'h1, 4'd2, 4'b1100, 1'b0, 1'b1, 1'b0);
    wait_idle();
    check("R9 asserted/released pattern", sel_at_lead, 4'b1001);
    check("R9 released after transfer", sel, 4'b1010);
    pol = 4'h0;
  endtask

  task automatic t_ignore();
    setup(0, 0, 1, 0, 0, 0, 0, 0);
    put(16'hF0F0, 4'd15, 4'h0, 1'b0, 1'b0, 1'b1);
    put(16'h1234, 4'd15, 4'h0, 1'b0, 1'b1, 1'b0);
    wait_idle();
    check("R11 ignored word gives no pulse", n_rx, 1);
    check("R11 kept word received", rx_log[0], rx_exp(16'h1234, 15));
  endtask

  task automatic t_full();
    setup(0, 0, 0, 7, 0, 0, 0, 0);
    put(16'h11, 4'd7, 4'h0, 1'b0, 1'b1, 1'b0);
    put(16'h22, 4'd7, 4'h0, 1'b0, 1'b1, 1'b0);
    check("R12 tx_ready low when slot full", tx_ready, 0);
    wr_data = 16'h33; wr_flen = 4'd7; wr_eot = 1'b1; wr_valid = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0;
    wait_idle();
    check("R12 dropped write not sent", n_rx, 2);
    check("R12 second word intact", rx_log[1], rx_exp(16'h22, 7));
  endtask

  task automatic t_idle();
    setup(0, 0, 0, 1, 0, 0, 0, 0);
    put(16'h7, 4'd3, 4'h0, 1'b0, 1'b0, 1'b0);
    while (n_rx < 1) @(negedge clk);
    repeat (4) @(negedge clk);
    check("R13 not idle while selects active", master_idle, 0);
    check("R13 select still asserted", sel, 4'h0);
    put(16'h8, 4'd3, 4'h0, 1'b0, 1'b1, 1'b0);
    wait_idle();
    check("R13 idle once released", master_idle, 1);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    clr_mon();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    t_reset();
    t_frame(0, 0, 0, 1, 16'h00A5, 7);
    t_frame(1, 1, 1, 2, 16'h0B3C, 11);
    t_frame(0, 1, 0, 0, 16'hC3A1, 15);
    t_frame(1, 0, 1, 3, 16'h0001, 0);
    t_delays(3, 2, 1);
    t_delays(0, 0, 2);
    t_frames(2, 1'b1, 1);
    t_frames(3, 1'b0, 0);
    t_xfer(4, 1);
    t_xfer(0, 2);
    t_selmask();
    t_ignore();
    t_full();
    t_idle();
    finish_run();
  end
endmodule